// File: doc/BRIEF.md
# Indexed Timing-Select Rate Divider (channel pair)

This block generates the sample-timing pulse for each channel of a converter pair. Each channel is steered by a 16-bit select word. The word either passes a serial-port word-select line straight through, or names one of five master-rate sources. A named source is divided by a ratio taken from a fixed 32-entry index table. Both select words sit in one 32-bit register that is loaded through a single write strobe. A separate enable vector gates each source's divider.

Each source arrives as a one-cycle tick in the block's clock domain. The divided output is a one-cycle pulse on every N-th enabled tick of the chosen source. Software chooses N by index, and the index table is irregular. A write that changes a channel's word restarts that channel's count. A write that leaves the word unchanged does not disturb it.

Top module: `tsel_pair_div`

## Requirements
- R1: After reset both select words read as 0x0600 (code 6, index 0), so each channel follows word-select line 0, and both outputs are low.
- R2: Source code 0..4 in word bits 10:8 selects `src_tick` bit 0..4 (clock A, clock B, clock C, generator A, generator B) as the tick that is counted.
- R3: Code 6 or 7 drives the channel output with word-select line (code − 6), delayed by one clock. Code 5 holds the output low.
- R4: Index (word bits 4:0) values 0, 1 and 2 divide by 2, 4 and 6.
- R5: Index 3 through 28 alternate between a power of two and one and a half times it: 8, 12, 16, 24, and so on. Index 27 gives 32768 and index 28 gives 49152.
- R6: Index 29 divides by 98304. The ratio 65536 belongs to no index.
- R7: Index 30 and 31 hold a divided channel's output low.
- R8: Channel 0 takes register bits 15:0 and channel 1 takes bits 31:16. The two channels count independently.
- R9: The divider for source s advances only while `div_en` bit s+1 is set. Other enable bits have no effect on it.
- R10: A divided output is high for exactly one clock, in the cycle after the edge that samples the N-th enabled tick since the last restart.
- R11: A write that changes a channel's word clears its count and suppresses any pulse at that edge, including a terminal tick in the same cycle. Rewriting the same word leaves the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load strobe for the select register |
| wr_data | input | 32 | New register value; channel 0 low half, channel 1 high half |
| div_en | input | 5 | Divider enables, indexed 1..5; bit s+1 enables source s |
| src_tick | input | 5 | One-cycle rate ticks of sources A, B, C, generator A, generator B |
| ws_in | input | 2 | Serial-port word-select lines 0 and 1 |
| tick_o | output | 2 | Timing pulse per channel |

## Verification
Two functions can fall in the same cycle: a restart caused by a select-word change, and the terminal tick of the running count. The bench lets a ratio-8 count run, then times a new word so that the write strobe is sampled on the same edge as the eighth tick. It expects no pulse at that edge, and a first pulse exactly two ticks later under the new ratio 2. A companion case rewrites the unchanged low half in mid-count and expects the period to stay at eight cycles.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int WORD_W  = 16;
  localparam int CODE_W  = 3;
  localparam int IDX_W   = 5;
  localparam int RATIO_W = 17;
  localparam int FIRST_WS_CODE = 6;
  localparam int LAST_IDX      = 29;

  typedef struct packed {
    logic [4:0]        spare_hi;
    logic [CODE_W-1:0] code;
    logic [2:0]        spare_mid;
    logic [IDX_W-1:0]  idx;
  } tsel_word_t;

  localparam logic [WORD_W-1:0] RESET_WORD = 16'h0600;

  // Divide ratio for a table index; zero marks a reserved index.
  function automatic logic [RATIO_W-1:0] tsel_ratio(input logic [IDX_W-1:0] idx);
    logic [RATIO_W-1:0] r;
    if (idx < IDX_W'(3)) begin
      r = (RATIO_W'(idx) + RATIO_W'(1)) << 1;
    end else if (idx == IDX_W'(LAST_IDX)) begin
      r = RATIO_W'(3) << 15;
    end else if (idx > IDX_W'(LAST_IDX)) begin
      r = '0;
    end else if (idx[0]) begin
      r = RATIO_W'(1) << ((idx + IDX_W'(3)) >> 1);
    end else begin
      r = RATIO_W'(3) << (idx >> 1);
    end
    return r;
  endfunction

  function automatic logic tsel_is_ws(input logic [CODE_W-1:0] code);
    return code >= CODE_W'(FIRST_WS_CODE);
  endfunction

endpackage

// File: rtl/tsel_src_pick.sv
module tsel_src_pick
  import tsel_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic [CODE_W-1:0] code,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [NSRC:1]     div_en,
  output logic              src_live,
  output logic              src_adv
);

  always_comb begin
    src_live = 1'b0;
    src_adv  = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (code == CODE_W'(s)) begin
        src_live = div_en[s+1];
        src_adv  = div_en[s+1] & src_tick[s];
      end
    end
  end

endmodule

// File: rtl/tsel_ratio_div.sv
module tsel_ratio_div
  import tsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               adv,
  input  logic [RATIO_W-1:0] ratio,
  output logic               hit
);

  logic [RATIO_W-1:0] cnt_q;
  logic               at_end;

  assign at_end = (cnt_q == ratio - RATIO_W'(1));
  assign hit    = adv & ~restart & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= at_end ? '0 : cnt_q + RATIO_W'(1);
    end
  end

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  assert_count_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != '0) |-> (cnt_q < ratio));

  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(cnt_q));

  assert_hit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/tsel_channel.sv
module tsel_channel
  import tsel_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int NWS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [NSRC-1:0]   src_tick,
  input  logic [NSRC:1]     div_en,
  input  logic [NWS-1:0]    ws_in,
  output logic              tick_o
);

  tsel_word_t         word_q;
  logic               restart;
  logic               ws_mode;
  logic               ws_line;
  logic               src_live;
  logic               src_adv;
  logic               div_adv;
  logic               reserved_idx;
  logic [RATIO_W-1:0] ratio;
  logic               hit;
  logic               out_q;

  assign restart      = wr_en & (wr_word != word_q);
  assign ws_mode      = tsel_is_ws(word_q.code);
  assign ratio        = tsel_ratio(word_q.idx);
  assign reserved_idx = (ratio == '0);
  assign div_adv      = src_adv & ~ws_mode & ~reserved_idx;

  always_comb begin
    ws_line = 1'b0;
    for (int w = 0; w < NWS; w++) begin
      if (word_q.code == CODE_W'(FIRST_WS_CODE + w)) ws_line = ws_in[w];
    end
  end

  tsel_src_pick #(.NSRC(NSRC)) u_pick (
    .code     (word_q.code),
    .src_tick (src_tick),
    .div_en   (div_en),
    .src_live (src_live),
    .src_adv  (src_adv)
  );

  tsel_ratio_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (div_adv),
    .ratio   (ratio),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= tsel_word_t'(RESET_WORD);
      out_q  <= 1'b0;
    end else begin
      if (wr_en) word_q <= tsel_word_t'(wr_word);
      if (restart)      out_q <= 1'b0;
      else if (ws_mode) out_q <= ws_line;
      else              out_q <= hit;
    end
  end

  assign tick_o = out_q;

  assert_ws_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_mode && !restart) |=> (out_q == $past(ws_line)));

  assert_reserved_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ws_mode && reserved_idx) |=> !out_q);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ws_mode && !src_live) |=> !out_q);

  assert_restart_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !out_q);

endmodule

// File: rtl/tsel_pair_div.sv
module tsel_pair_div
  import tsel_pkg::*;
#(
  parameter int NSRC = 5,
  parameter int NWS  = 2,
  parameter int NCH  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NCH*WORD_W-1:0] wr_data,
  input  logic [NSRC:1]         div_en,
  input  logic [NSRC-1:0]       src_tick,
  input  logic [NWS-1:0]        ws_in,
  output logic [NCH-1:0]        tick_o
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tsel_channel #(.NSRC(NSRC), .NWS(NWS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_word  (wr_data[c*WORD_W +: WORD_W]),
      .src_tick (src_tick),
      .div_en   (div_en),
      .ws_in    (ws_in),
      .tick_o   (tick_o[c])
    );
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |=> (tick_o == '0));

endmodule

// File: tb/tsel_pair_div_tb.sv
`timescale 1ns/1ps
module tsel_pair_div_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:1]  div_en = '1;
  logic [4:0]  src_tick = '0;
  logic [1:0]  ws_in = '0;
  logic [1:0]  tick_o;

  int  nvec = 0;
  int  nfail = 0;
  bit  done = 1'b0;
  int  tick_mode = 0;
  int  tcnt = 0;
  longint exp_ratio [32];

  always #10 clk = ~clk;

  tsel_pair_div u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .div_en(div_en), .src_tick(src_tick), .ws_in(ws_in), .tick_o(tick_o)
  );

  always @(negedge clk) begin
    tcnt++;
    for (int s = 0; s < 5; s++)
      src_tick[s] = (tick_mode == 0) ? 1'b1 : ((tcnt % (s + 1)) == 0);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Cycles after the write edge until the first pulse on channel ch.
  task automatic first_pulse(input int ch, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tick_o[ch]) return;
    end
    n = -1;
  endtask

  task automatic quiet_cycles(input int ch, input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick_o[ch]) seen++;
    end
  endtask

  task automatic period(input int ch, input int limit, output int n);
    int d;
    first_pulse(ch, limit, d);
    first_pulse(ch, limit, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int n, n0, n1, seen;
    logic prev_ws;
    // ratio table built by successive multiplication
    exp_ratio[0] = 2; exp_ratio[1] = 4; exp_ratio[2] = 6;
    exp_ratio[3] = 8;
    for (int i = 4; i <= 28; i++)
      exp_ratio[i] = (i % 2 == 0) ? exp_ratio[i-1] * 3 / 2 : exp_ratio[i-1] * 4 / 3;
    exp_ratio[29] = exp_ratio[28] * 2;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs low in reset", tick_o, 0);
    rst_n = 1'b1;
    @(negedge clk); ws_in = 2'b01;
    @(posedge clk); @(negedge clk);
    chk("R1 reset word follows ws line 0", tick_o, 3);
    ws_in = 2'b10;
    @(posedge clk); @(negedge clk);
    chk("R1 reset word ignores ws line 1", tick_o, 0);

    // R3: ws pass-through on both channels
    write_reg(32'h0700_0600);
    prev_ws = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ws_in = 2'((i * 5) >> 1);
      @(posedge clk); @(negedge clk);
      chk("R3 ch0 follows ws line 0", tick_o[0], ws_in[0]);
      chk("R3 ch1 follows ws line 1 (R8)", tick_o[1], ws_in[1]);
    end
    ws_in = '0;

    // R4 R5: index sweep on channel 0, source A ticking every cycle
    tick_mode = 0;
    for (int i = 0; i <= 22; i++) begin
      write_reg({16'h0600, 16'(i)});
      first_pulse(0, 8000, n);
      chk(i < 3 ? "R4 small ratio" : "R5 geometric ratio", n, exp_ratio[i]);
      write_reg(32'h0600_0600);
    end

    // R6 R8: index 29 on ch0 and index 28 on ch1 in parallel
    write_reg(32'h001C_001D);
    n0 = -1; n1 = -1;
    for (int k = 1; k <= 98310; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick_o[0] && n0 < 0) n0 = k;
      if (tick_o[1] && n1 < 0) n1 = k;
      if (n0 >= 0) break;
    end
    chk("R6 index 29 ratio", n0, 98304);
    chk("R5 index 28 ratio on ch1 (R8)", n1, 49152);
    write_reg(32'h0600_0600);

    // R2: distinct source periods, ratio 4
    tick_mode = 1;
    for (int s = 0; s < 5; s++) begin
      write_reg({16'h0600, 5'd0, 3'(s), 8'h01});
      period(0, 200, n);
      chk("R2 source selected by code", n, 4 * (s + 1));
    end

    // R9: enable bit s+1 gates source s
    tick_mode = 0;
    for (int s = 0; s < 5; s++) begin
      div_en = ~(5'(1) << s);
      write_reg({16'h0600, 5'd0, 3'(s), 8'h00});
      quiet_cycles(0, 30, seen);
      chk("R9 cleared enable holds output low", seen, 0);
      div_en = '1;
      period(0, 50, n);
      chk("R9 set enable runs divider", n, 2);
    end

    // R7: reserved indices; R3: code 5
    write_reg(32'h0600_001E);
    quiet_cycles(0, 40, seen);
    chk("R7 index 30 low", seen, 0);
    write_reg(32'h0600_001F);
    quiet_cycles(0, 40, seen);
    chk("R7 index 31 low", seen, 0);
    write_reg(32'h0600_0501);
    quiet_cycles(0, 40, seen);
    chk("R3 code 5 low", seen, 0);

    // R10: pulse width one cycle, period = ratio
    write_reg(32'h0600_0003);
    first_pulse(0, 50, n);
    @(posedge clk); @(negedge clk);
    chk("R10 pulse lasts one cycle", tick_o[0], 0);
    first_pulse(0, 50, n);
    chk("R10 period equals ratio", n, 7);

    // R11: unchanged rewrite keeps count (ratio 8)
    first_pulse(0, 50, n);
    n = 0;
    while (n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 2) begin wr_en = 1'b1; wr_data = 32'h0700_0003; end
      else wr_en = 1'b0;
      if (tick_o[0]) break;
    end
    chk("R11 same word keeps count (R8 upper half write)", n, 8);

    // R11: changed word restarts mid-count (new ratio 4)
    n = 0;
    while (n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 2) begin wr_en = 1'b1; wr_data = 32'h0700_0001; end
      else wr_en = 1'b0;
      if (tick_o[0]) break;
    end
    chk("R11 changed word restarts count", n, 7);

    // R11: restart on the same edge as the terminal tick (8 -> ratio 2)
    write_reg(32'h0600_0003);
    first_pulse(0, 50, n);
    n = 0;
    while (n < 50) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 7) begin wr_en = 1'b1; wr_data = 32'h0600_0000; end
      else wr_en = 1'b0;
      if (tick_o[0]) break;
    end
    chk("R11 restart suppresses terminal pulse", n, 10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule